// File: doc/BRIEF.md
# First-Come Shared Bus Arbiter

This block is a clocked stand-in for a wide internal bus that many logic groups can drive. Tristate drivers are replaced by enable-gated multiplexing into a held register per lane. The bus is 108 bits wide, built from twelve 9-bit lanes, each lane carrying one byte plus its parity bit. A mode input groups the lanes into twelve, six or three partitions. Each partition keeps its own owner.

Each requester presents two byte-wide slots and a starting lane. It asks for the partition that holds that lane. The first requester to reach an idle partition owns it and keeps it for as long as it keeps asking. Later requesters wait and are recorded as overlaps. They do not disturb the bus. A lane that nobody writes keeps its last value.

The requester side follows valid/ready rules. A requester's valid is either of its byte enables. `req_ready` high means its bytes are accepted in that cycle. A requester that sees ready low holds its request and waits for ownership. Dropping valid while it owns the partition gives the partition up. Mode, owner, overlap and bus outputs are plain status pins.

Top module: `sfa_bus`

## Requirements
- R1: While reset is low and after its release, every `own_valid` bit, `own_idx` field, `overlap` bit and bus bit is zero, and `mode_active` is 00.
- R2: Lane l occupies `bus_out[9l+8:9l]`. A lane's partition number is l for mode 00 (twelve 9-bit partitions), l/2 for mode 01 (six 18-bit), l/4 for mode 10 (three 36-bit), and l for the reserved mode 11.
- R3: A requester is valid when either bit of its two `req_be` bits is set. It targets the partition of its `req_lane`. A `req_lane` of 12 or more makes no request.
- R4: An idle partition is granted, at the next clock edge, to the lowest-indexed valid requester that targets it. `own_idx` reads zero while `own_valid` is low.
- R5: An owner keeps its partition, with an unchanged index, for as long as it stays valid and targets that partition. Other requesters change neither owner nor bus.
- R6: When the owner stops requesting its partition, a waiting requester that is still valid owns the partition from the next cycle on. If nobody is waiting, the partition becomes idle.
- R7: `req_ready[r]` is high exactly when requester r is valid and already owns its target partition. In that cycle, byte b (`req_data` bits [9b+8:9b]) with its enable set is written to lane `req_lane`+b. The write happens only if that lane exists and lies in the same partition. The value appears on `bus_out` one cycle later.
- R8: Any lane that is not written holds its previous value. With no requester ready, the whole bus is unchanged the next cycle.
- R9: `overlap[p]` becomes set after any cycle in which partition p's owner keeps it while another valid requester targets p. It stays set until reset.
- R10: `cfg_mode` is adopted into `mode_active` only at an edge where no partition is owned and the two differ. No grant is made at that edge. While any partition is owned, the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Requested partition mode |
| req_be | input | NUM_REQ*2 | Byte enables; either bit is the requester's valid |
| req_lane | input | NUM_REQ*4 | Starting lane per requester |
| req_data | input | NUM_REQ*18 | Two 9-bit bytes per requester |
| req_ready | output | NUM_REQ | Requester owns its target partition; bytes accepted |
| bus_out | output | 108 | Resolved, held bus |
| own_valid | output | 12 | Partition has an owner |
| own_idx | output | 12*IDX_W | Owner index per partition |
| overlap | output | 12 | Sticky blocked-request flag per partition |
| mode_active | output | 2 | Mode in force |

## Verification
The bench builds the block with four requesters instead of six, keeping the full 108-bit width and all three groupings. Four requesters over random lanes often land on the same partition. This makes simultaneous first requests, blocked overlaps and handovers frequent in every mode. It also lets the lowest-index tie-break and the cross-partition byte-1 rule show up in both the 18-bit and 36-bit groupings. Starting lanes beyond the last lane and mode changes attempted while partitions are owned are mixed in as well.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

  typedef enum logic [1:0] {
    MODE_X1  = 2'b00,
    MODE_X2  = 2'b01,
    MODE_X4  = 2'b10,
    MODE_RSV = 2'b11
  } part_mode_e;

  // lanes per partition = 1 << shift
  function automatic logic [1:0] mode_shift(input logic [1:0] m);
    case (part_mode_e'(m))
      MODE_X2: return 2'd1;
      MODE_X4: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sfa_part_arb.sv
module sfa_part_arb #(
  parameter int NUM_REQ = 6,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] hit,
  output logic               own_v,
  output logic [IDX_W-1:0]   own_i,
  output logic               ovl
);

  logic               keep;
  logic               found;
  logic [IDX_W-1:0]   sel;
  logic [NUM_REQ-1:0] others;

  always_comb begin
    keep   = own_v && hit[own_i];
    found  = 1'b0;
    sel    = '0;
    others = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (hit[r] && !found) begin
        found = 1'b1;
        sel   = IDX_W'(r);
      end
      if (hit[r] && (own_i != IDX_W'(r))) others[r] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_v <= 1'b0;
      own_i <= '0;
      ovl   <= 1'b0;
    end else begin
      if (!keep) begin
        own_v <= found;
        own_i <= found ? sel : '0;
      end
      if (keep && (|others)) ovl <= 1'b1;
    end
  end

endmodule

// File: rtl/sfa_lane_hold.sv
module sfa_lane_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
  end

endmodule

// File: rtl/sfa_bus.sv
module sfa_bus
  import sfa_pkg::*;
#(
  parameter int NUM_REQ   = 6,
  parameter int LANES     = 12,
  parameter int LANE_W    = 9,
  parameter int REQ_BYTES = 2,
  parameter int LSEL_W    = 4,
  localparam int IDX_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int SLOT_W   = REQ_BYTES * LANE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    cfg_mode,
  input  logic [NUM_REQ*REQ_BYTES-1:0]  req_be,
  input  logic [NUM_REQ*LSEL_W-1:0]     req_lane,
  input  logic [NUM_REQ*SLOT_W-1:0]     req_data,
  output logic [NUM_REQ-1:0]            req_ready,
  output logic [LANES*LANE_W-1:0]       bus_out,
  output logic [LANES-1:0]              own_valid,
  output logic [LANES*IDX_W-1:0]        own_idx,
  output logic [LANES-1:0]              overlap,
  output logic [1:0]                    mode_active
);

  logic [1:0]         mode_q;
  logic [1:0]         shift;
  logic               mode_upd;
  logic [NUM_REQ-1:0] rq_ok;
  logic [LSEL_W-1:0]  rq_tgt  [NUM_REQ];
  logic [NUM_REQ-1:0] hit     [LANES];
  logic [IDX_W-1:0]   own_i   [LANES];
  logic [LANES-1:0]   wr_en;
  logic [LANE_W-1:0]  wr_data [LANES];

  assign shift       = mode_shift(mode_q);
  assign mode_upd    = !(|own_valid) && (cfg_mode != mode_q);
  assign mode_active = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= MODE_X1;
    else if (mode_upd) mode_q <= cfg_mode;
  end

  // request decode
  always_comb begin
    for (int r = 0; r < NUM_REQ; r++) begin
      rq_ok[r]  = (|req_be[r*REQ_BYTES +: REQ_BYTES]) &&
                  (req_lane[r*LSEL_W +: LSEL_W] < LSEL_W'(LANES));
      rq_tgt[r] = req_lane[r*LSEL_W +: LSEL_W] >> shift;
    end
  end

  always_comb begin
    for (int p = 0; p < LANES; p++)
      for (int r = 0; r < NUM_REQ; r++)
        hit[p][r] = rq_ok[r] && !mode_upd && (rq_tgt[r] == LSEL_W'(p));
  end

  always_comb begin
    for (int r = 0; r < NUM_REQ; r++)
      req_ready[r] = rq_ok[r] && own_valid[rq_tgt[r]] &&
                     (own_i[rq_tgt[r]] == IDX_W'(r));
  end

  // lane write selection
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      wr_en[l]   = 1'b0;
      wr_data[l] = '0;
      for (int r = 0; r < NUM_REQ; r++) begin
        for (int b = 0; b < REQ_BYTES; b++) begin
          logic [LSEL_W:0] lb;
          lb = {1'b0, req_lane[r*LSEL_W +: LSEL_W]} + (LSEL_W+1)'(b);
          if (req_ready[r] && req_be[r*REQ_BYTES+b] &&
              (lb == (LSEL_W+1)'(l)) &&
              ((lb >> shift) == {1'b0, rq_tgt[r]})) begin
            wr_en[l]   = 1'b1;
            wr_data[l] = req_data[r*SLOT_W + b*LANE_W +: LANE_W];
          end
        end
      end
    end
  end

  generate
    for (genvar p = 0; p < LANES; p++) begin : g_part
      sfa_part_arb #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit[p]),
        .own_v (own_valid[p]),
        .own_i (own_i[p]),
        .ovl   (overlap[p])
      );
      assign own_idx[p*IDX_W +: IDX_W] = own_i[p];
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      sfa_lane_hold #(.W(LANE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en[l]),
        .wr_data (wr_data[l]),
        .q       (bus_out[l*LANE_W +: LANE_W])
      );
    end
  endgenerate

endmodule

// File: rtl/sfa_bus_chk.sv
module sfa_bus_chk #(
  parameter int NUM_REQ = 6,
  parameter int LANES   = 12,
  parameter int LANE_W  = 9,
  parameter int IDX_W   = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_REQ-1:0]      req_ready,
  input logic [LANES*LANE_W-1:0] bus_out,
  input logic [LANES-1:0]        own_valid,
  input logic [LANES*IDX_W-1:0]  own_idx,
  input logic [LANES-1:0]        overlap,
  input logic [1:0]              mode_active
);

  logic [NUM_REQ-1:0] owns_any;

  always_comb begin
    owns_any = '0;
    for (int p = 0; p < LANES; p++)
      for (int r = 0; r < NUM_REQ; r++)
        if (own_valid[p] && own_idx[p*IDX_W +: IDX_W] == IDX_W'(r)) owns_any[r] = 1'b1;
  end

  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|own_valid) |=> $stable(mode_active));

  p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready == '0) |=> $stable(bus_out));

  generate
    for (genvar p = 0; p < LANES; p++) begin : g_p
      p_idle_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !own_valid[p] |-> (own_idx[p*IDX_W +: IDX_W] == '0));
      p_owner_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_valid[p] && req_ready[own_idx[p*IDX_W +: IDX_W]]) |=>
        (own_valid[p] && $stable(own_idx[p*IDX_W +: IDX_W])));
      p_overlap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overlap[p] |=> overlap[p]);
    end
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_r
      p_ready_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready[r] |-> owns_any[r]);
    end
  endgenerate

endmodule

bind sfa_bus sfa_bus_chk #(
  .NUM_REQ (NUM_REQ),
  .LANES   (LANES),
  .LANE_W  (LANE_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .bus_out     (bus_out),
  .own_valid   (own_valid),
  .own_idx     (own_idx),
  .overlap     (overlap),
  .mode_active (mode_active)
);

// File: tb/tb_sfa_bus.sv
`timescale 1ns/1ps
module tb_sfa_bus;
  localparam int NR = 4;
  localparam int NL = 12;
  localparam int IW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cfg_mode = 2'b00;
  logic [1:0]        be   [NR];
  logic [3:0]        lane [NR];
  logic [17:0]       dat  [NR];
  logic [NR*2-1:0]   req_be;
  logic [NR*4-1:0]   req_lane;
  logic [NR*18-1:0]  req_data;
  logic [NR-1:0]     req_ready;
  logic [NL*9-1:0]   bus_out;
  logic [NL-1:0]     own_valid;
  logic [NL*IW-1:0]  own_idx;
  logic [NL-1:0]     overlap;
  logic [1:0]        mode_active;

  int n_chk = 0;
  int n_fail = 0;

  // model state
  logic [1:0] m_mode;
  logic       m_ov  [NL];
  int         m_oi  [NL];
  logic       m_ovl [NL];
  logic [8:0] m_bus [NL];

  always #10 clk = ~clk;

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      req_be[r*2 +: 2]     = be[r];
      req_lane[r*4 +: 4]   = lane[r];
      req_data[r*18 +: 18] = dat[r];
    end
  end

  sfa_bus #(.NUM_REQ(NR)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .req_be(req_be), .req_lane(req_lane), .req_data(req_data),
    .req_ready(req_ready), .bus_out(bus_out), .own_valid(own_valid),
    .own_idx(own_idx), .overlap(overlap), .mode_active(mode_active));

  function automatic int sh(input logic [1:0] m);
    return (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : 0;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NL*9-1:0] exp_bus();
    logic [NL*9-1:0] v;
    for (int l = 0; l < NL; l++) v[l*9 +: 9] = m_bus[l];
    return v;
  endfunction

  task automatic compare_all();
    logic [NL-1:0]    ev, eo;
    logic [NL*IW-1:0] ei;
    logic [NR-1:0]    er;
    int s;
    s = sh(m_mode);
    for (int p = 0; p < NL; p++) begin
      ev[p] = m_ov[p];
      eo[p] = m_ovl[p];
      ei[p*IW +: IW] = IW'(m_oi[p]);
    end
    for (int r = 0; r < NR; r++) begin
      int t;
      t = int'(lane[r]) >> s;
      er[r] = (be[r] != 0) && (lane[r] < 12) && m_ov[t] && (m_oi[t] == r);
    end
    check("R10 mode_active", 128'(mode_active), 128'(m_mode));
    check("R4/R5/R6 own_valid", 128'(own_valid), 128'(ev));
    check("R4/R5/R6 own_idx", 128'(own_idx), 128'(ei));
    check("R9 overlap", 128'(overlap), 128'(eo));
    check("R8 bus_out", 128'(bus_out), 128'(exp_bus()));
    check("R7 req_ready", 128'(req_ready), 128'(er));
  endtask

  task automatic model_reset();
    m_mode = 2'b00;
    for (int p = 0; p < NL; p++) begin
      m_ov[p] = 1'b0; m_oi[p] = 0; m_ovl[p] = 1'b0; m_bus[p] = '0;
    end
  endtask

  // one clock: check current outputs, advance model and DUT
  task automatic step();
    int s, t[NR];
    logic ok[NR], rdy[NR], idle, upd;
    logic       n_ov [NL];
    int         n_oi [NL];
    #1;
    compare_all();
    s = sh(m_mode);
    idle = 1'b1;
    for (int p = 0; p < NL; p++) if (m_ov[p]) idle = 1'b0;
    upd = idle && (cfg_mode != m_mode);
    for (int r = 0; r < NR; r++) begin
      t[r]   = int'(lane[r]) >> s;
      ok[r]  = (be[r] != 0) && (lane[r] < 12) && !upd;
      rdy[r] = (be[r] != 0) && (lane[r] < 12) && m_ov[t[r]] && (m_oi[t[r]] == r);
    end
    for (int r = 0; r < NR; r++)
      if (rdy[r])
        for (int b = 0; b < 2; b++) begin
          int l;
          l = int'(lane[r]) + b;
          if (be[r][b] && l < NL && (l >> s) == t[r]) m_bus[l] = dat[r][b*9 +: 9];
        end
    for (int p = 0; p < NL; p++) begin
      logic keep, other, got;
      keep = m_ov[p] && ok[m_oi[p]] && (t[m_oi[p]] == p);
      other = 1'b0; got = 1'b0;
      n_ov[p] = 1'b0; n_oi[p] = 0;
      for (int r = 0; r < NR; r++) begin
        if (ok[r] && t[r] == p && r != m_oi[p]) other = 1'b1;
        if (ok[r] && t[r] == p && !got) begin got = 1'b1; n_ov[p] = 1'b1; n_oi[p] = r; end
      end
      if (keep) begin
        n_ov[p] = 1'b1; n_oi[p] = m_oi[p];
        if (other) m_ovl[p] = 1'b1;
      end
    end
    for (int p = 0; p < NL; p++) begin m_ov[p] = n_ov[p]; m_oi[p] = n_oi[p]; end
    if (upd) m_mode = cfg_mode;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_req();
    for (int r = 0; r < NR; r++) begin be[r] = 2'b00; lane[r] = '0; dat[r] = '0; end
  endtask

  initial begin
    #(20 * 60000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    clear_req();
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 own_valid", 128'(own_valid), 128'(0));
    check("R1 bus_out", 128'(bus_out), 128'(0));
    check("R1 overlap", 128'(overlap), 128'(0));
    check("R1 mode_active", 128'(mode_active), 128'(0));
    rst_n = 1'b1;

    // R4: tie on idle partition 3, lowest index wins
    be[1] = 2'b01; lane[1] = 4'd3; dat[1] = 18'h0_0A5;
    be[2] = 2'b01; lane[2] = 4'd3; dat[2] = 18'h0_15A;
    step();
    check("R4 tie owner", 128'(own_idx[3*IW +: IW]), 128'(1));
    check("R7 ready owner only", 128'(req_ready), 128'(4'b0010));
    step();
    check("R7 bus written", 128'(bus_out[27 +: 9]), 128'(9'h0A5));
    check("R5/R9 owner kept, overlap", 128'({own_idx[3*IW +: IW], overlap[3]}), 128'({2'd1, 1'b1}));
    // R6: owner releases, waiter takes over next cycle
    be[1] = 2'b00;
    step();
    check("R6 handover", 128'({own_valid[3], own_idx[3*IW +: IW]}), 128'({1'b1, 2'd2}));
    step();
    check("R7 new owner data", 128'(bus_out[27 +: 9]), 128'(9'h15A));
    be[2] = 2'b00;
    step();
    step();
    check("R8 hold when idle", 128'(bus_out[27 +: 9]), 128'(9'h15A));
    // R3: lane beyond range makes no request
    be[0] = 2'b11; lane[0] = 4'd13;
    step();
    check("R3 out-of-range lane", 128'(own_valid), 128'(0));
    clear_req();
    // R10/R2: switch to 36-bit grouping while idle, lane 5 -> partition 1
    cfg_mode = 2'b10;
    be[3] = 2'b01; lane[3] = 4'd5; dat[3] = 18'h3_1FF;
    step();
    check("R10 no grant at mode change", 128'({mode_active, own_valid}), 128'({2'b10, 12'h000}));
    step();
    check("R2 partition of lane 5", 128'(own_valid), 128'(12'h002));
    cfg_mode = 2'b00;
    step();
    check("R10 mode frozen while owned", 128'(mode_active), 128'(2'b10));
    // R2: byte 1 crossing a partition boundary is dropped (mode 10, lane 7)
    be[3] = 2'b11; lane[3] = 4'd7; dat[3] = 18'h1FF_00 >> 0;
    step(); step(); step();
    check("R2 cross-partition byte", 128'(bus_out[72 +: 9]), 128'(0));
    clear_req();
    step(); step();

    // constrained random
    for (int c = 0; c < 3000; c++) begin
      for (int r = 0; r < NR; r++) begin
        if (($urandom % 100) < 30) begin
          be[r]   = ($urandom % 3 == 0) ? 2'b00 : 2'($urandom);
          lane[r] = ($urandom % 10 == 0) ? 4'(12 + $urandom % 4) : 4'($urandom % 12);
          dat[r]  = 18'($urandom);
        end else if (req_ready[r]) begin
          dat[r] = 18'($urandom);
        end
      end
      if (($urandom % 100) < 4) cfg_mode = 2'($urandom);
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule